// File: doc/BRIEF.md
# SPI Slave Ready-Handshake Controller

This controller sits on the peripheral side of a five-wire SPI link, where a ready line next to the usual four wires lets the peripheral ask the host for a transfer. A byte-level SPI slave engine does the bit shifting. It gives this block a strobe and the byte for every completed transfer, plus the chip-select level. It takes back a load pulse with the byte to shift out on the next transfer. On the user side, a single-cycle request names what to send: the flow-off byte, the flow-on byte, or an arbitrary data byte. The block reports busy while the request is in flight and pulses done when the byte has left.

The block raises the ready line only while chip select is idle. It hands over the pending byte only after the host clocks in an explicit acknowledge byte. If the host opens a message of its own at the same moment, the block drops ready and lets that message run, then raises ready again. A programmable timeout drops ready when the host stays silent, so no interleaving of the two sides can leave the peripheral waiting forever.

Top module: `spi_rdy_ctrl`

## Requirements
- R1: After reset, rdy_o, tx_load_o, done_o and busy_o are all low.
- R2: A request (req_i high for one cycle while busy_o is low) is accepted, and busy_o is high from the next cycle until the cycle after done_o. While busy_o is low, rdy_o, tx_load_o and done_o stay low.
- R3: rdy_o rises only in a cycle that follows a cycle with cs_n_i high. While cs_n_i is held low, an accepted request keeps rdy_o low.
- R4: With rdy_o high, a received byte 8'h08 makes rdy_o fall in the next cycle. In that same cycle tx_load_o pulses for one cycle, with tx_byte_o holding the requested byte.
- R5: After the load, the first received byte of any value marks the transfer that carried the byte out. done_o pulses high for exactly one cycle in the next cycle, and busy_o falls one cycle later.
- R6: With rdy_o high, a received byte 8'h05 makes rdy_o fall in the next cycle with no load. rdy_o rises again only after cs_n_i is seen high, and a fresh 8'h08 is then needed.
- R7: With timeout_i non-zero and no acknowledge or start byte, rdy_o stays high for exactly timeout_i cycles. It is then low for at least one cycle, and rises again once cs_n_i is high.
- R8: With timeout_i equal to zero, rdy_o stays high until an 8'h08 or 8'h05 arrives.
- R9: Received bytes other than 8'h08 and 8'h05 while rdy_o is high are ignored, and the wait and its timeout run on. Bytes received while idle have no effect.
- R10: The transmitted byte is selected by req_kind_i: 0 sends req_byte_i, 1 sends the FLOW_OFF_BYTE parameter (default 8'h07), 2 sends 8'h06, and 3 sends req_byte_i. A request raised while busy_o is high is ignored and does not change the byte.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cs_n_i | input | 1 | Chip-select level from the SPI slave engine, low when the host is selecting |
| rx_valid_i | input | 1 | One-cycle strobe for each completed byte transfer |
| rx_byte_i | input | 8 | Byte received in that transfer |
| tx_load_o | output | 1 | One-cycle pulse that loads tx_byte_o into the engine |
| tx_byte_o | output | 8 | Byte for the engine to shift out |
| req_i | input | 1 | Request to send one byte |
| req_kind_i | input | 2 | Byte selector: 0 data, 1 flow-off, 2 flow-on, 3 data |
| req_byte_i | input | 8 | Data byte for kinds 0 and 3 |
| timeout_i | input | TMO_W | Cycles the ready line may stay high unanswered; 0 disables |
| done_o | output | 1 | One-cycle pulse when the byte has been transferred |
| busy_o | output | 1 | Request in flight |
| rdy_o | output | 1 | Ready line to the host |

## Verification
Every output comes from a register, so each response is due exactly one clock edge after the input cycle that causes it. A captured acknowledge shows up as a falling rdy_o and a tx_load_o pulse one cycle later. done_o follows the carrying transfer by one cycle, busy_o falls one cycle after that, and ready is re-raised one cycle after chip select is seen high. The bench drives inputs on the falling edge and keeps a behavioural model that advances on the rising edge, so model and design are compared on every falling edge, with the same one-edge latency. Directed checks then sample at the negedge that ends each send, which is the first cycle in which the response is visible. Ready-high durations are counted in whole cycles against timeout_i.

// File: rtl/spi_rdy_pkg.sv
package spi_rdy_pkg;
  localparam logic [7:0] ACK_BYTE     = 8'h08;
  localparam logic [7:0] SOM_BYTE     = 8'h05;
  localparam logic [7:0] FLOW_ON_BYTE = 8'h06;

  typedef enum logic [1:0] {
    KIND_DATA     = 2'd0,
    KIND_FLOW_OFF = 2'd1,
    KIND_FLOW_ON  = 2'd2,
    KIND_DATA_ALT = 2'd3
  } req_kind_e;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_WAIT_CS,
    ST_REQ,
    ST_LOAD,
    ST_XFER,
    ST_DONE
  } rdy_state_e;
endpackage

// File: rtl/spi_rdy_rx_class.sv
module spi_rdy_rx_class #(
  parameter logic [7:0] ACK = 8'h08,
  parameter logic [7:0] SOM = 8'h05
) (
  input  logic       valid_i,
  input  logic [7:0] byte_i,
  output logic       ack_o,
  output logic       som_o
);
  assign ack_o = valid_i && (byte_i == ACK);
  assign som_o = valid_i && (byte_i == SOM);
endmodule

// File: rtl/spi_rdy_timer.sv
module spi_rdy_timer #(
  parameter int W = 16
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         run_i,
  input  logic [W-1:0] limit_i,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] last;

  assign last = limit_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     cnt_q <= '0;
    else if (!run_i) cnt_q <= '0;
    else             cnt_q <= cnt_q + 1'b1;
  end

  // limit of zero never expires
  assign expire_o = run_i && (limit_i != '0) && (cnt_q == last);
endmodule

// File: rtl/spi_rdy_ctrl.sv
module spi_rdy_ctrl
  import spi_rdy_pkg::*;
#(
  parameter logic [7:0] FLOW_OFF_BYTE = 8'h07,
  parameter int         TMO_W         = 16
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cs_n_i,
  input  logic             rx_valid_i,
  input  logic [7:0]       rx_byte_i,
  output logic             tx_load_o,
  output logic [7:0]       tx_byte_o,
  input  logic             req_i,
  input  logic [1:0]       req_kind_i,
  input  logic [7:0]       req_byte_i,
  input  logic [TMO_W-1:0] timeout_i,
  output logic             done_o,
  output logic             busy_o,
  output logic             rdy_o
);
  rdy_state_e st_q, st_d;
  logic [7:0] byte_q, byte_sel;
  logic       got_ack, got_som, expired;

  spi_rdy_rx_class #(.ACK(ACK_BYTE), .SOM(SOM_BYTE)) u_class (
    .valid_i (rx_valid_i),
    .byte_i  (rx_byte_i),
    .ack_o   (got_ack),
    .som_o   (got_som)
  );

  spi_rdy_timer #(.W(TMO_W)) u_timer (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .run_i    (st_q == ST_REQ),
    .limit_i  (timeout_i),
    .expire_o (expired)
  );

  always_comb begin
    unique case (req_kind_i)
      KIND_FLOW_OFF: byte_sel = FLOW_OFF_BYTE;
      KIND_FLOW_ON:  byte_sel = FLOW_ON_BYTE;
      default:       byte_sel = req_byte_i;
    endcase
  end

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:    if (req_i) st_d = ST_WAIT_CS;
      ST_WAIT_CS: if (cs_n_i) st_d = ST_REQ;
      ST_REQ: begin
        // acknowledge wins; a host message start or silence re-arms
        if (got_ack)      st_d = ST_LOAD;
        else if (got_som) st_d = ST_WAIT_CS;
        else if (expired) st_d = ST_WAIT_CS;
      end
      ST_LOAD:    st_d = ST_XFER;
      ST_XFER:    if (rx_valid_i) st_d = ST_DONE;
      ST_DONE:    st_d = ST_IDLE;
      default:    st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      byte_q <= '0;
    end else begin
      st_q <= st_d;
      if (st_q == ST_IDLE && req_i) byte_q <= byte_sel;
    end
  end

  assign rdy_o     = (st_q == ST_REQ);
  assign tx_load_o = (st_q == ST_LOAD);
  assign tx_byte_o = byte_q;
  assign done_o    = (st_q == ST_DONE);
  assign busy_o    = (st_q != ST_IDLE);
endmodule

// File: rtl/spi_rdy_ctrl_chk.sv
module spi_rdy_ctrl_chk #(
  parameter int TMO_W = 16
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             cs_n_i,
  input logic             rx_valid_i,
  input logic [7:0]       rx_byte_i,
  input logic             tx_load_o,
  input logic [7:0]       tx_byte_o,
  input logic [TMO_W-1:0] timeout_i,
  input logic             done_o,
  input logic             busy_o,
  input logic             rdy_o
);
  logic [TMO_W:0] run_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    run_q <= '0;
    else if (rdy_o) run_q <= run_q + 1'b1;
    else            run_q <= '0;
  end

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_o |-> (!rdy_o && !tx_load_o && !done_o)); // R2
  AST_RDY_RISE_CS_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rdy_o) |-> $past(cs_n_i)); // R3
  AST_LOAD_AFTER_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tx_load_o |-> $past(rdy_o && rx_valid_i && rx_byte_i == 8'h08)); // R4
  AST_DONE_SINGLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> (!done_o && !busy_o)); // R5
  AST_SOM_REARM: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && rx_valid_i && rx_byte_i == 8'h05) |=> (!rdy_o && !tx_load_o)); // R6
  AST_TMO_WINDOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rdy_o && timeout_i != '0) |-> (run_q < {1'b0, timeout_i})); // R7
  AST_BYTE_HELD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (busy_o && $past(busy_o)) |-> $stable(tx_byte_o)); // R10
endmodule

bind spi_rdy_ctrl spi_rdy_ctrl_chk #(.TMO_W(TMO_W)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .cs_n_i     (cs_n_i),
  .rx_valid_i (rx_valid_i),
  .rx_byte_i  (rx_byte_i),
  .tx_load_o  (tx_load_o),
  .tx_byte_o  (tx_byte_o),
  .timeout_i  (timeout_i),
  .done_o     (done_o),
  .busy_o     (busy_o),
  .rdy_o      (rdy_o)
);

// File: tb/spi_rdy_ctrl_tb.sv
module spi_rdy_ctrl_tb;
  localparam int TMO_W = 16;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cs_n = 1'b1, rx_valid = 1'b0, req = 1'b0;
  logic [7:0] rx_byte = 8'h00, req_byte = 8'h00;
  logic [1:0] req_kind = 2'd0;
  logic [TMO_W-1:0] tmo = 16'd20;
  logic tx_load, done, busy, rdy;
  logic [7:0] tx_byte;

  int n_tests = 0, n_fail = 0;
  bit finished = 0;

  always #5 clk = ~clk;

  spi_rdy_ctrl #(.TMO_W(TMO_W)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .cs_n_i(cs_n), .rx_valid_i(rx_valid),
    .rx_byte_i(rx_byte), .tx_load_o(tx_load), .tx_byte_o(tx_byte),
    .req_i(req), .req_kind_i(req_kind), .req_byte_i(req_byte),
    .timeout_i(tmo), .done_o(done), .busy_o(busy), .rdy_o(rdy)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference: phase 0 idle, 1 wait cs, 2 ready, 3 load, 4 carry, 5 done
  int m_ph = 0, m_cnt = 0;
  logic [7:0] m_byte = 8'h00;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ph = 0; m_cnt = 0; m_byte = 8'h00;
    end else begin
      case (m_ph)
        0: if (req) begin
             m_byte = (req_kind == 2'd1) ? 8'h07 : (req_kind == 2'd2) ? 8'h06 : req_byte;
             m_ph = 1;
           end
        1: if (cs_n) begin m_ph = 2; m_cnt = 0; end
        2: begin
             if (rx_valid && rx_byte == 8'h08) m_ph = 3;
             else if (rx_valid && rx_byte == 8'h05) m_ph = 1;
             else if (tmo != 0 && m_cnt + 1 >= int'(tmo)) m_ph = 1;
             else m_cnt++;
           end
        3: m_ph = 4;
        4: if (rx_valid) m_ph = 5;
        default: m_ph = 0;
      endcase
    end
  end

  always @(negedge clk) begin
    if (rst_n && !finished) begin
      chk(rdy == (m_ph == 2), "R3 rdy vs model", rdy, m_ph == 2);
      chk(tx_load == (m_ph == 3), "R4 load vs model", tx_load, m_ph == 3);
      if (m_ph == 3) chk(tx_byte == m_byte, "R10 byte vs model", tx_byte, m_byte);
      chk(done == (m_ph == 5), "R5 done vs model", done, m_ph == 5);
      chk(busy == (m_ph != 0), "R2 busy vs model", busy, m_ph != 0);
    end
  end

  task automatic tick(); @(negedge clk); endtask

  task automatic send(input logic [7:0] b);
    rx_valid = 1'b1; rx_byte = b;
    tick();
    rx_valid = 1'b0;
  endtask

  task automatic request(input logic [1:0] k, input logic [7:0] b);
    req = 1'b1; req_kind = k; req_byte = b;
    tick();
    req = 1'b0;
  endtask

  task automatic wait_rdy();
    while (!rdy) tick();
  endtask

  task automatic ack_and_finish(input logic [7:0] exp_b, input string tag);
    send(8'h08);
    chk(tx_load == 1'b1 && rdy == 1'b0, {tag, " load after ack"}, {tx_load, rdy}, 2'b10);
    chk(tx_byte == exp_b, {tag, " tx byte"}, tx_byte, exp_b);
    tick();
    send(8'h5A);
    chk(done == 1'b1, "R5 done after carrying transfer", done, 1);
    tick();
    chk(done == 1'b0 && busy == 1'b0, "R5 done single, busy low", {done, busy}, 0);
  endtask

  initial begin
    repeat (3) tick();
    chk(!rdy && !tx_load && !done && !busy, "R1 reset outputs", {rdy, tx_load, done, busy}, 0);
    rst_n = 1'b1;
    tick();

    // flow-off with an ignored byte in between
    request(2'd1, 8'h00);
    chk(busy == 1'b1, "R2 busy after request", busy, 1);
    wait_rdy();
    send(8'hAA);
    chk(rdy == 1'b1 && tx_load == 1'b0, "R9 stray byte ignored", {rdy, tx_load}, 2'b10);
    ack_and_finish(8'h07, "R4");

    // bytes while idle have no effect
    send(8'h08);
    chk(!busy && !tx_load && !rdy, "R9 idle ack ignored", {busy, tx_load, rdy}, 0);
    tick();

    // chip select low holds the request
    cs_n = 1'b0;
    request(2'd2, 8'h00);
    for (int i = 0; i < 10; i++) begin
      chk(rdy == 1'b0, "R3 no ready while cs low", rdy, 0);
      tick();
    end
    cs_n = 1'b1;
    tick();
    tick();
    chk(rdy == 1'b1, "R3 ready after cs high", rdy, 1);
    ack_and_finish(8'h06, "R10");

    // collision with a host message start
    request(2'd0, 8'h3C);
    wait_rdy();
    req = 1'b1; req_kind = 2'd0; req_byte = 8'h99;
    cs_n = 1'b0;
    send(8'h05);
    req = 1'b0;
    chk(rdy == 1'b0 && tx_load == 1'b0, "R6 ready drops on start byte", {rdy, tx_load}, 0);
    send(8'h01);
    send(8'h08);
    chk(rdy == 1'b0 && tx_load == 1'b0, "R6 host message runs", {rdy, tx_load}, 0);
    tick();
    cs_n = 1'b1;
    tick();
    tick();
    chk(rdy == 1'b1, "R6 re-armed after cs high", rdy, 1);
    ack_and_finish(8'h3C, "R10 busy request ignored");

    // timeout
    tmo = 16'd5;
    request(2'd3, 8'hC3);
    wait_rdy();
    begin
      int run = 0;
      while (rdy) begin run++; tick(); end
      chk(run == 5, "R7 ready window length", run, 5);
    end
    tick();
    chk(rdy == 1'b1, "R7 retry after cs high", rdy, 1);
    ack_and_finish(8'hC3, "R7");

    // timeout disabled
    tmo = '0;
    request(2'd1, 8'h00);
    wait_rdy();
    repeat (100) tick();
    chk(rdy == 1'b1, "R8 ready held without timeout", rdy, 1);
    ack_and_finish(8'h07, "R8");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_tests++; n_fail++;
    finished = 1;
    $display("FAIL watchdog expired actual=0 expected=1");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule